// File: doc/BRIEF.md
# Passive serial configuration target

This block is the receiving end of a serial configuration link that an external host drives. The host supplies the configuration clock and one data bit per clock. The block counts the bits it accepts against the size of its own image. Once that share is complete, it hands the link to the next device in a daisy chain by pulling its chip-enable output low, and it stops holding the shared done line low.

When the wired-AND done line reads high, every device on the chain has finished loading. The block then runs a fixed initialization count and enters user mode. An active-low reconfigure input returns the block to idle at any time, and its rising edge starts a new load. A data-error input marks a corrupted load. On an error the block pulls the shared status line low and keeps done low until the next reconfigure.

The open-drain status and done lines are modelled as a pair: an output enable, where 1 means "pull the line low", and a read-back input that carries the resolved line level. An optional init-done output falls when an enable bit in the first data frame is captured. It rises again when user mode begins.

Top module: `ps_cfg_target`

## Requirements
- R1: While `cfg_reload_n` is low, `status_oe`=1 and `done_oe`=1. Also `chain_en_n`=1, `user_mode`=0 and `init_done`=1.
- R2: At the first rising clock edge after `cfg_reload_n` goes high, `status_oe` drops to 0. `done_oe` stays 1 until all image bits have been captured.
- R3: A bit on `cfg_data` is captured on a rising edge only when `chip_en_n`=0. Edges with `chip_en_n`=1 are not counted.
- R4: At the edge that captures bit number IMAGE_BITS (64 by default), `chain_en_n` goes to 0 and `done_oe` goes to 0. Before that edge both stay at their loading values (1 and 1).
- R5: After the block has released done, initialization does not start while `done_in` reads 0, and `user_mode` stays 0.
- R6: Call E0 the first rising edge at which the block is waiting with `done_in`=1. After the 136th edge counted from E0, `user_mode` is still 0. After the 137th edge it is 1 (one edge to leave the wait, then INIT_CYCLES=136 initialization clocks).
- R7: Bits are numbered from 0 in capture order. The first frame is FRAME_BITS=32 bits, and the init-done enable bit is bit OPT_POS=3. If that bit is 1, `init_done` goes to 0 at the edge that captures it and returns to 1 together with `user_mode`. If that bit is 0, `init_done` stays 1.
- R8: If `data_err`=1 at an edge that would capture a bit, then from that edge `status_oe`=1, `done_oe`=1 and `chain_en_n`=1. These values hold, whatever data follows, until `cfg_reload_n` goes low.
- R9: Pulling `cfg_reload_n` low during a load discards the bits counted so far. The next load again needs a full IMAGE_BITS bits before handoff.
- R10: An edge with `status_in`=0 (another device flagging an error) captures no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock from the host |
| cfg_reload_n | input | 1 | Active-low reconfigure; low holds idle, rising edge starts a load |
| chip_en_n | input | 1 | Active-low chip enable from the previous device or ground |
| cfg_data | input | 1 | Serial configuration data |
| data_err | input | 1 | Marks the bit at this edge as corrupted |
| status_in | input | 1 | Resolved level of the shared status line |
| done_in | input | 1 | Resolved level of the shared done line |
| status_oe | output | 1 | 1 = pull the status line low |
| done_oe | output | 1 | 1 = pull the done line low |
| chain_en_n | output | 1 | Active-low chip enable for the next device |
| init_done | output | 1 | Low between enable-bit capture and user mode |
| user_mode | output | 1 | High once initialization is complete |

## Verification
The assertions assume that `cfg_reload_n` is the only reset. They also assume that inputs change away from the rising edge of `cfg_clk`, and that `done_in` and `status_in` are the wired-AND of this block's own enables with those of the other devices. The bench keeps to this by deriving both read-back inputs from the block's enables, combined with per-line "other device holds low" flags. Every input changes one time unit after a rising edge. Reconfigure is also released just after an edge, so the asynchronous reset never coincides with a capture.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_RELEASE,
      ST_INIT,
      ST_USER,
      ST_FAULT
   } cfg_state_t;

endpackage

// File: rtl/ps_cfg_bitcap.sv
module ps_cfg_bitcap #(
   parameter int IMAGE_BITS = 64,
   parameter int FRAME_BITS = 32,
   parameter int OPT_POS    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic capture,
   input  logic data,
   output logic last_bit,
   output logic opt_en
);

   localparam int CW = $clog2(IMAGE_BITS + 1);

   if (IMAGE_BITS < 2) begin : g_chk_img
      $error("IMAGE_BITS must be at least 2");
   end
   if (FRAME_BITS > IMAGE_BITS) begin : g_chk_frame
      $error("FRAME_BITS must not exceed IMAGE_BITS");
   end
   if (OPT_POS >= FRAME_BITS) begin : g_chk_opt
      $error("OPT_POS must lie inside the first frame");
   end

   logic [CW-1:0] bit_cnt;
   logic          opt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         opt_q   <= 1'b0;
      end else if (capture) begin
         bit_cnt <= bit_cnt + 1'b1;
         if (bit_cnt == CW'(OPT_POS)) begin
            opt_q <= data;
         end
      end
   end

   assign last_bit = (bit_cnt == CW'(IMAGE_BITS - 1));
   assign opt_en   = opt_q;

   // R3: a capture never happens beyond the image size
   assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      capture |-> (bit_cnt < CW'(IMAGE_BITS)));

   // R7: option bit only changes on a capture edge
   assert_opt_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(capture) |-> $stable(opt_q));

endmodule

// File: rtl/ps_cfg_inittimer.sv
module ps_cfg_inittimer #(
   parameter int INIT_CYCLES = 136
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);

   localparam int TW = $clog2(INIT_CYCLES + 1);

   if (INIT_CYCLES < 1) begin : g_chk_init
      $error("INIT_CYCLES must be at least 1");
   end

   logic [TW-1:0] tick_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_cnt <= '0;
      end else if (!run) begin
         tick_cnt <= '0;
      end else begin
         tick_cnt <= tick_cnt + 1'b1;
      end
   end

   assign expired = run && (tick_cnt == TW'(INIT_CYCLES - 1));

   // R6: the timer never runs past its window
   assert_init_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (tick_cnt < TW'(INIT_CYCLES)));

endmodule

// File: rtl/ps_cfg_ctrl.sv
module ps_cfg_ctrl
   import ps_cfg_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic chip_en_n,
   input  logic status_in,
   input  logic done_in,
   input  logic data_err,
   input  logic last_bit,
   input  logic init_expired,
   output logic capture,
   output logic init_run,
   output logic status_oe,
   output logic done_oe,
   output logic chain_en_n,
   output logic user_mode
);

   cfg_state_t state, state_nx;
   logic       bit_edge;

   assign bit_edge = (state == ST_LOAD) && !chip_en_n && status_in;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:    state_nx = ST_LOAD;
         ST_LOAD: begin
            if (bit_edge) begin
               if (data_err)      state_nx = ST_FAULT;
               else if (last_bit) state_nx = ST_RELEASE;
            end
         end
         ST_RELEASE: if (done_in) state_nx = ST_INIT;
         ST_INIT:    if (init_expired) state_nx = ST_USER;
         ST_USER:    state_nx = ST_USER;
         ST_FAULT:   state_nx = ST_FAULT;
         default:    state_nx = ST_FAULT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nx;
   end

   assign capture    = bit_edge && !data_err;
   assign init_run   = (state == ST_INIT);
   assign status_oe  = (state == ST_IDLE) || (state == ST_FAULT);
   assign done_oe    = (state == ST_IDLE) || (state == ST_LOAD) || (state == ST_FAULT);
   assign chain_en_n = !((state == ST_RELEASE) || (state == ST_INIT) || (state == ST_USER));
   assign user_mode  = (state == ST_USER);

   // R6: user mode holds until reconfigure
   assert_user_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      user_mode |=> user_mode);

   // R6: user mode is only reached through initialization
   assert_user_after_init_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(user_mode) |-> $past(init_run));

   // R4: handoff follows the capture of the last bit
   assert_chain_handoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(chain_en_n) |-> $past(capture && last_bit));

   // R8: an error keeps both lines pulled and the chain closed
   assert_fault_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (status_oe && done_oe && chain_en_n && $past(bit_edge && data_err))
      |=> (status_oe && done_oe && chain_en_n));

endmodule

// File: rtl/ps_cfg_target.sv
module ps_cfg_target #(
   parameter int IMAGE_BITS   = 64,
   parameter int FRAME_BITS   = 32,
   parameter int OPT_POS      = 3,
   parameter int INIT_CYCLES  = 136,
   parameter bit USE_INIT_PIN = 1'b1
) (
   input  logic cfg_clk,
   input  logic cfg_reload_n,
   input  logic chip_en_n,
   input  logic cfg_data,
   input  logic data_err,
   input  logic status_in,
   input  logic done_in,
   output logic status_oe,
   output logic done_oe,
   output logic chain_en_n,
   output logic init_done,
   output logic user_mode
);

   logic capture;
   logic last_bit;
   logic opt_en;
   logic init_run;
   logic init_expired;

   ps_cfg_bitcap #(
      .IMAGE_BITS (IMAGE_BITS),
      .FRAME_BITS (FRAME_BITS),
      .OPT_POS    (OPT_POS)
   ) i_bitcap (
      .clk      (cfg_clk),
      .rst_n    (cfg_reload_n),
      .capture  (capture),
      .data     (cfg_data),
      .last_bit (last_bit),
      .opt_en   (opt_en)
   );

   ps_cfg_inittimer #(
      .INIT_CYCLES (INIT_CYCLES)
   ) i_inittimer (
      .clk     (cfg_clk),
      .rst_n   (cfg_reload_n),
      .run     (init_run),
      .expired (init_expired)
   );

   ps_cfg_ctrl i_ctrl (
      .clk          (cfg_clk),
      .rst_n        (cfg_reload_n),
      .chip_en_n    (chip_en_n),
      .status_in    (status_in),
      .done_in      (done_in),
      .data_err     (data_err),
      .last_bit     (last_bit),
      .init_expired (init_expired),
      .capture      (capture),
      .init_run     (init_run),
      .status_oe    (status_oe),
      .done_oe      (done_oe),
      .chain_en_n   (chain_en_n),
      .user_mode    (user_mode)
   );

   if (USE_INIT_PIN) begin : g_init_pin
      assign init_done = !(opt_en && !user_mode);
   end else begin : g_no_init_pin
      logic unused_opt;
      assign unused_opt = opt_en;
      assign init_done  = 1'b1;
   end

endmodule

// File: tb/test_ps_cfg_target.sv
module test_ps_cfg_target;

   localparam int CLK_PERIOD = 10;
   localparam int IMG   = 64;
   localparam int OPTP  = 3;
   localparam int INITN = 136;

   logic cfg_clk = 1'b0;
   logic cfg_reload_n = 1'b0;
   logic chip_en_n = 1'b1;
   logic cfg_data = 1'b0;
   logic data_err = 1'b0;
   logic hold_status = 1'b0;
   logic hold_done = 1'b0;
   logic status_in, done_in;
   logic status_oe, done_oe, chain_en_n, init_done, user_mode;

   int errors = 0;
   int checks = 0;

   always #(CLK_PERIOD/2) cfg_clk = ~cfg_clk;

   assign status_in = !(status_oe | hold_status);
   assign done_in   = !(done_oe | hold_done);

   ps_cfg_target i_ps_cfg_target (
      .cfg_clk      (cfg_clk),
      .cfg_reload_n (cfg_reload_n),
      .chip_en_n    (chip_en_n),
      .cfg_data     (cfg_data),
      .data_err     (data_err),
      .status_in    (status_in),
      .done_in      (done_in),
      .status_oe    (status_oe),
      .done_oe      (done_oe),
      .chain_en_n   (chain_en_n),
      .init_done    (init_done),
      .user_mode    (user_mode)
   );

   task automatic check(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge cfg_clk);
      #1;
   endtask

   task automatic send_bit(input logic b);
      chip_en_n = 1'b0;
      cfg_data  = b;
      tick();
   endtask

   function automatic logic pat(input int i, input logic en);
      if (i == OPTP) return en;
      return logic'((i % 3) == 0);
   endfunction

   task automatic reload_seq(input string req);
      cfg_reload_n = 1'b0;
      chip_en_n = 1'b1;
      data_err = 1'b0;
      hold_status = 1'b0;
      hold_done = 1'b0;
      tick();
      tick();
      check(req, "status_oe in reload", status_oe, 1'b1);
      check(req, "done_oe in reload", done_oe, 1'b1);
      check(req, "chain_en_n in reload", chain_en_n, 1'b1);
      check(req, "user_mode in reload", user_mode, 1'b0);
      check(req, "init_done in reload", init_done, 1'b1);
      cfg_reload_n = 1'b1;
      tick();
      check("R2", "status released", status_oe, 1'b0);
      check("R2", "done held at start", done_oe, 1'b1);
   endtask

   // R3 R10 R4 R5 R6 R7: full load with gaps and stalls
   task automatic test_full(input logic en);
      reload_seq("R1");
      for (int i = 0; i < IMG - 1; i++) begin
         if (i == 10) begin
            chip_en_n = 1'b1;
            repeat (3) tick();
         end
         if (i == 20) begin
            chip_en_n = 1'b0;
            hold_status = 1'b1;
            repeat (4) tick();
            hold_status = 1'b0;
         end
         send_bit(pat(i, en));
         if (i == OPTP) check("R7", "init_done after enable bit", init_done, !en);
      end
      check("R4", "chain closed before last bit", chain_en_n, 1'b1);
      check("R2", "done held during load", done_oe, 1'b1);
      hold_done = 1'b1;
      send_bit(pat(IMG - 1, en));
      chip_en_n = 1'b1;
      check("R4", "chain open after last bit", chain_en_n, 1'b0);
      check("R4", "done released after last bit", done_oe, 1'b0);
      repeat (20) tick();
      check("R5", "no user mode while done low", user_mode, 1'b0);
      hold_done = 1'b0;
      repeat (INITN) tick();
      check("R6", "user_mode before window end", user_mode, 1'b0);
      check("R7", "init_done during init", init_done, !en);
      tick();
      check("R6", "user_mode at window end", user_mode, 1'b1);
      check("R7", "init_done in user mode", init_done, 1'b1);
   endtask

   // R8: data error
   task automatic test_error();
      reload_seq("R1");
      for (int i = 0; i < 10; i++) send_bit(1'b0);
      data_err = 1'b1;
      send_bit(1'b1);
      data_err = 1'b0;
      check("R8", "status pulled on error", status_oe, 1'b1);
      check("R8", "done pulled on error", done_oe, 1'b1);
      check("R8", "chain closed on error", chain_en_n, 1'b1);
      for (int i = 0; i < IMG + 10; i++) send_bit(1'b1);
      chip_en_n = 1'b1;
      check("R8", "status still pulled", status_oe, 1'b1);
      check("R8", "done still pulled", done_oe, 1'b1);
      check("R8", "chain still closed", chain_en_n, 1'b1);
      check("R8", "no user mode", user_mode, 1'b0);
   endtask

   // R9: reconfigure in the middle of a load
   task automatic test_midreload();
      reload_seq("R1");
      for (int i = 0; i < 20; i++) send_bit(1'b1);
      reload_seq("R9");
      for (int i = 0; i < IMG - 1; i++) send_bit(1'b0);
      check("R9", "chain closed one bit short", chain_en_n, 1'b1);
      send_bit(1'b0);
      chip_en_n = 1'b1;
      check("R9", "chain open after full image", chain_en_n, 1'b0);
   endtask

   initial begin
      test_full(1'b1);
      test_full(1'b0);
      test_error();
      test_midreload();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule